// File: doc/BRIEF.md
# Fractional-N PLL Rate Solver

This block turns a requested output frequency and a reference frequency into the settings a fractional-N synthesizer needs. It produces three results: an integer multiplier, a 40-bit fraction word and a band code for the oscillator. If the request cannot be met, it raises an error flag. A single pulse on `start` begins the work. The solver then holds `busy` while a restoring divider produces one quotient bit per clock. It signals the end with a one-cycle `done`. Its results stay unchanged until the next `done`.

The division works on the dividend `{req_hz, 32'b0}` divided by `ref_hz`. The upper half of the quotient is the integer multiplier. The lower half is the 32-bit fraction. The fraction is either truncated or rounded up, and it sits in the upper bits of the 40-bit fraction word.

From the chosen settings the solver recomputes the achieved frequency and uses it to pick the band. A reverse mode skips the divider. It takes a multiplier and a fraction word as inputs and reports the frequency they produce one cycle after `start`.

Top module: `frac_pll_solver`

## Requirements
- R1: In forward mode with a nonzero reference, `busy` is 1 from the clock edge that samples `start` until `done` rises. `done` is 1 in the cycle after the 65th rising edge that follows the edge that sampled `start`, and `busy` is 0 in that same cycle.
- R2: The multiplier is floor(req/ref). In truncate mode (`round_up`=0), the 32-bit fraction is floor((req mod ref)·2^32 / ref).
- R3: In round-up mode (`round_up`=1), the fraction is one larger than the truncated value whenever that second division leaves a nonzero remainder. A carry out of the fraction goes into the multiplier.
- R4: When req is an exact multiple of ref, the fraction is 0 in both rounding modes.
- R5: `frac_out` holds the 32-bit fraction in bits 39:8. Bits 7:0 are 0.
- R6: `rate_out` is ref·mult + floor(ref·fraction / 2^32), computed at 64 bits.
- R7: In round-up mode, a result with `rate_out` different from the request sets `err`. With in-band requests, round-up results report `rate_out` equal to the request.
- R8: The band comes from the achieved rate using inclusive ranges, checked in this order with the first match winning: 250–500 MHz gives code 3, 500–1000 MHz gives code 2, 1000–1500 MHz gives code 1, 1500–2000 MHz gives code 0. A rate that matches no range sets `err`. Whenever `err` is set, `mult_out`, `frac_out`, `band_out` and `rate_out` all read 0.
- R9: Reverse mode (`rev_mode`=1) does not use the divider and returns results in the cycle after `start`:
  - `rate_out` is computed from `mult_in` and `frac_in[39:8]`.
  - `frac_in[7:0]` is ignored.
  - When `frac_en`=0, the fraction counts as 0.
  - `mult_out` echoes `mult_in`.
  - `frac_out` is the effective fraction in bits 39:8.
  - `band_out` is 0 and `err` is 0.
- R10: A `start` with `ref_hz`=0 never raises `busy`. `done` and `err` are 1 in the next cycle, and all results are 0.
- R11: `done` lasts exactly one cycle. The outputs change only in a cycle where `done` is 1. A `start` that arrives while `busy` is 1 is ignored. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a computation (sampled when not busy) |
| rev_mode | input | 1 | 1 = compute the rate from the given settings |
| round_up | input | 1 | Forward mode: 1 = round the fraction up, 0 = truncate |
| req_hz | input | 32 | Requested frequency in Hz |
| ref_hz | input | 32 | Reference frequency in Hz |
| mult_in | input | 32 | Reverse mode: integer multiplier |
| frac_in | input | 40 | Reverse mode: fraction word, fraction in bits 39:8 |
| frac_en | input | 1 | Reverse mode: 0 = treat the fraction as zero |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request invalid |
| mult_out | output | 32 | Integer multiplier |
| frac_out | output | 40 | Fraction word |
| band_out | output | 2 | Oscillator band code |
| rate_out | output | 64 | Achieved frequency in Hz |

## Verification
A 19.2 MHz reference with a 1 GHz request leaves a remainder of one twelfth. Running it in both rounding modes separates truncation from round-up. It also shows that the round-up result lands exactly on the request, while the truncated one falls 1 Hz short. An exact multiple of the reference exercises the zero-remainder path. Requests placed exactly on each band edge, and just outside the outer limits, show whether the range checks are inclusive, whether the lower band wins where two ranges meet, and whether errors clear the outputs. Reverse mode is tried with garbage in the low fraction bits and with the fraction disabled, and a second `start` is pulsed mid-division to show it has no effect.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        FPS_IDLE = 2'd0,
        FPS_DIV  = 2'd1,
        FPS_FIN  = 2'd2
    } fps_state_e;
endpackage

// File: rtl/fps_div_step.sv
// One restoring-division step: bring in one dividend bit, try a subtract.
module fps_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic         q_o
);
    logic [W:0] trial;
    logic [W:0] diff;

    always_comb begin
        trial = {rem_i, bit_i};
        diff  = trial - {1'b0, dvs_i};
        q_o   = (trial >= {1'b0, dvs_i});
        rem_o = q_o ? diff[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/fps_rate_calc.sv
// Achieved rate = (ref * {mult, frac}) >> FRAC_W.
module fps_rate_calc #(
    parameter int W      = 32,
    parameter int FRAC_W = 32
) (
    input  logic [W-1:0]          ref_i,
    input  logic [W+FRAC_W-1:0]   q_i,
    output logic [2*W-1:0]        rate_o
);
    localparam int Q_W = W + FRAC_W;
    localparam int P_W = W + Q_W;

    logic [P_W-1:0] prod;

    always_comb begin
        prod   = {{Q_W{1'b0}}, ref_i} * {{W{1'b0}}, q_i};
        rate_o = prod[FRAC_W +: 2*W];
    end
endmodule

// File: rtl/fps_band_sel.sv
// Inclusive range match per band; lowest index wins on overlap.
module fps_band_sel #(
    parameter int W         = 32,
    parameter int NUM_BANDS = 4,
    parameter int BAND_W    = 2,
    parameter logic [NUM_BANDS-1:0][W-1:0]      LO   = '0,
    parameter logic [NUM_BANDS-1:0][W-1:0]      HI   = '0,
    parameter logic [NUM_BANDS-1:0][BAND_W-1:0] CODE = '0
) (
    input  logic [2*W-1:0]    rate_i,
    output logic              hit_o,
    output logic [BAND_W-1:0] code_o
);
    logic [NUM_BANDS-1:0] match;

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        assign match[g] = (rate_i >= {{W{1'b0}}, LO[g]}) &&
                          (rate_i <= {{W{1'b0}}, HI[g]});
    end

    always_comb begin
        hit_o  = 1'b0;
        code_o = '0;
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_o  = 1'b1;
                code_o = CODE[i];
            end
        end
    end
endmodule

// File: rtl/frac_pll_solver.sv
module frac_pll_solver
    import fps_pkg::*;
#(
    parameter int W         = 32,
    parameter int FRAC_W    = 32,
    parameter int REG_W     = 40,
    parameter int NUM_BANDS = 4,
    parameter int BAND_W    = 2,
    parameter logic [NUM_BANDS-1:0][W-1:0] BAND_LO =
        {32'd1500000000, 32'd1000000000, 32'd500000000, 32'd250000000},
    parameter logic [NUM_BANDS-1:0][W-1:0] BAND_HI =
        {32'd2000000000, 32'd1500000000, 32'd1000000000, 32'd500000000},
    parameter logic [NUM_BANDS-1:0][BAND_W-1:0] BAND_CODE =
        {2'd0, 2'd1, 2'd2, 2'd3}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rev_mode,
    input  logic              round_up,
    input  logic [W-1:0]      req_hz,
    input  logic [W-1:0]      ref_hz,
    input  logic [W-1:0]      mult_in,
    input  logic [REG_W-1:0]  frac_in,
    input  logic              frac_en,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [W-1:0]      mult_out,
    output logic [REG_W-1:0]  frac_out,
    output logic [BAND_W-1:0] band_out,
    output logic [2*W-1:0]    rate_out
);
    localparam int Q_W   = W + FRAC_W;
    localparam int SHIFT = REG_W - FRAC_W;
    localparam int STEPS = Q_W;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam logic [REG_W-1:0] KEEP = {{FRAC_W{1'b1}}, {SHIFT{1'b0}}};

    typedef struct packed {
        fps_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [Q_W-1:0]    dvd;
        logic [W-1:0]      rem;
        logic [W-1:0]      dvs;
        logic [W-1:0]      tgt;
        logic              rup;
        logic              busy;
        logic              done;
        logic              err;
        logic [W-1:0]      mult;
        logic [REG_W-1:0]  frac;
        logic [BAND_W-1:0] band;
        logic [2*W-1:0]    rate;
    } state_t;

    state_t r_q, r_d;

    // divider datapath
    logic [W-1:0] step_rem;
    logic         step_q;

    fps_div_step #(.W(W)) u_step (
        .rem_i (r_q.rem),
        .bit_i (r_q.dvd[Q_W-1]),
        .dvs_i (r_q.dvs),
        .rem_o (step_rem),
        .q_o   (step_q)
    );

    // shared rate multiplier: rounded quotient in FIN, given settings in IDLE
    logic [REG_W-1:0] frac_keep;
    logic [Q_W-1:0]   q_rnd;
    logic [Q_W-1:0]   q_rev;
    logic [W-1:0]     calc_ref;
    logic [Q_W-1:0]   calc_q;
    logic [2*W-1:0]   rate_w;
    logic             band_hit;
    logic [BAND_W-1:0] band_w;

    always_comb begin
        frac_keep = frac_en ? (frac_in & KEEP) : '0;
        q_rev     = {mult_in, {FRAC_W{1'b0}}} |
                    ({{(Q_W-REG_W){1'b0}}, frac_keep} >> SHIFT);
        q_rnd     = r_q.dvd + Q_W'(r_q.rup && (r_q.rem != '0));
        calc_ref  = (r_q.st == FPS_FIN) ? r_q.dvs : ref_hz;
        calc_q    = (r_q.st == FPS_FIN) ? q_rnd : q_rev;
    end

    fps_rate_calc #(.W(W), .FRAC_W(FRAC_W)) u_rate (
        .ref_i  (calc_ref),
        .q_i    (calc_q),
        .rate_o (rate_w)
    );

    fps_band_sel #(
        .W(W), .NUM_BANDS(NUM_BANDS), .BAND_W(BAND_W),
        .LO(BAND_LO), .HI(BAND_HI), .CODE(BAND_CODE)
    ) u_band (
        .rate_i (rate_w),
        .hit_o  (band_hit),
        .code_o (band_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            FPS_IDLE: begin
                if (start) begin
                    if (ref_hz == '0) begin
                        r_d.err  = 1'b1;
                        r_d.mult = '0;
                        r_d.frac = '0;
                        r_d.band = '0;
                        r_d.rate = '0;
                        r_d.done = 1'b1;
                    end else if (rev_mode) begin
                        r_d.err  = 1'b0;
                        r_d.mult = mult_in;
                        r_d.frac = frac_keep;
                        r_d.band = '0;
                        r_d.rate = rate_w;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = FPS_DIV;
                        r_d.busy = 1'b1;
                        r_d.dvd  = {req_hz, {FRAC_W{1'b0}}};
                        r_d.rem  = '0;
                        r_d.dvs  = ref_hz;
                        r_d.tgt  = req_hz;
                        r_d.rup  = round_up;
                        r_d.cnt  = CNT_W'(STEPS);
                    end
                end
            end
            FPS_DIV: begin
                r_d.rem = step_rem;
                r_d.dvd = {r_q.dvd[Q_W-2:0], step_q};
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CNT_W'(1)) r_d.st = FPS_FIN;
            end
            FPS_FIN: begin
                r_d.st   = FPS_IDLE;
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                r_d.err  = !band_hit ||
                           (r_q.rup && (rate_w != {{W{1'b0}}, r_q.tgt}));
                if (r_d.err) begin
                    r_d.mult = '0;
                    r_d.frac = '0;
                    r_d.band = '0;
                    r_d.rate = '0;
                end else begin
                    r_d.mult = q_rnd[Q_W-1:FRAC_W];
                    r_d.frac = {q_rnd[FRAC_W-1:0], {SHIFT{1'b0}}};
                    r_d.band = band_w;
                    r_d.rate = rate_w;
                end
            end
            default: r_d.st = FPS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy     = r_q.busy;
    assign done     = r_q.done;
    assign err      = r_q.err;
    assign mult_out = r_q.mult;
    assign frac_out = r_q.frac;
    assign band_out = r_q.band;
    assign rate_out = r_q.rate;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mult_out) && $stable(frac_out) && $stable(rate_out)
                   && $stable(band_out) && $stable(err)));

    // R5
    frac_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (frac_out[SHIFT-1:0] == '0));

    // R10
    zero_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (ref_hz == '0)) |=> (done && err && !busy));

    // R1
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (rate_out == '0 && mult_out == '0 && band_out == '0));
endmodule

// File: tb/frac_pll_solver_tb.sv
module frac_pll_solver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rev_mode = 1'b0;
    logic        round_up = 1'b0;
    logic [31:0] req_hz = '0;
    logic [31:0] ref_hz = '0;
    logic [31:0] mult_in = '0;
    logic [39:0] frac_in = '0;
    logic        frac_en = 1'b0;
    logic        busy, done, err;
    logic [31:0] mult_out;
    logic [39:0] frac_out;
    logic [1:0]  band_out;
    logic [63:0] rate_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit run_chk = 1'b0;
    string cur_tag = "R2";

    always #5 clk = ~clk;

    frac_pll_solver dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rev_mode(rev_mode),
        .round_up(round_up), .req_hz(req_hz), .ref_hz(ref_hz),
        .mult_in(mult_in), .frac_in(frac_in), .frac_en(frac_en),
        .busy(busy), .done(done), .err(err), .mult_out(mult_out),
        .frac_out(frac_out), .band_out(band_out), .rate_out(rate_out)
    );

    task automatic chk(input logic ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic        m_busy, m_done;
    int          m_cnt;
    logic        e_err, p_err;
    logic [31:0] e_mult, p_mult;
    logic [39:0] e_frac, p_frac;
    logic [1:0]  e_band, p_band;
    logic [63:0] e_rate, p_rate;

    task automatic predict();
        logic [63:0] num, q, r;
        logic [95:0] prod;
        logic [31:0] fr;
        logic        hit;
        logic [1:0]  code;
        p_err = 1'b0; p_mult = '0; p_frac = '0; p_band = '0; p_rate = '0;
        if (ref_hz == 0) begin
            p_err = 1'b1;
        end else if (rev_mode) begin
            fr     = frac_en ? frac_in[39:8] : 32'd0;
            prod   = 96'(ref_hz) * 96'({mult_in, fr});
            p_rate = prod[95:32];
            p_mult = mult_in;
            p_frac = {fr, 8'h00};
        end else begin
            num = {req_hz, 32'h0};
            q   = num / 64'(ref_hz);
            r   = num % 64'(ref_hz);
            if (round_up && r != 0) q = q + 1;
            prod = 96'(ref_hz) * 96'(q);
            hit = 1'b1;
            if (prod[95:32] >= 250000000 && prod[95:32] <= 500000000) code = 2'd3;
            else if (prod[95:32] >= 500000000 && prod[95:32] <= 1000000000) code = 2'd2;
            else if (prod[95:32] >= 1000000000 && prod[95:32] <= 1500000000) code = 2'd1;
            else if (prod[95:32] >= 1500000000 && prod[95:32] <= 2000000000) code = 2'd0;
            else begin hit = 1'b0; code = 2'd0; end
            p_err = !hit || (round_up && prod[95:32] != 64'(req_hz));
            if (!p_err) begin
                p_mult = q[63:32];
                p_frac = {q[31:0], 8'h00};
                p_band = code;
                p_rate = prod[95:32];
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_cnt = 0;
            e_err = 0; e_mult = 0; e_frac = 0; e_band = 0; e_rate = 0;
        end else begin
            m_done = 1'b0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0; m_done = 1;
                    e_err = p_err; e_mult = p_mult; e_frac = p_frac;
                    e_band = p_band; e_rate = p_rate;
                end
            end else if (start) begin
                predict();
                if (ref_hz == 0 || rev_mode) begin
                    m_done = 1;
                    e_err = p_err; e_mult = p_mult; e_frac = p_frac;
                    e_band = p_band; e_rate = p_rate;
                end else begin
                    m_busy = 1; m_cnt = 65;
                end
            end
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (run_chk) begin
            chk(busy == m_busy, "R1 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R11 done", 64'(done), 64'(m_done));
            chk(err == e_err, {cur_tag, " err"}, 64'(err), 64'(e_err));
            chk(mult_out == e_mult, {cur_tag, " mult"}, 64'(mult_out), 64'(e_mult));
            chk(frac_out == e_frac, {cur_tag, " frac"}, 64'(frac_out), 64'(e_frac));
            chk(band_out == e_band, {cur_tag, " band"}, 64'(band_out), 64'(e_band));
            chk(rate_out == e_rate, {cur_tag, " rate"}, rate_out, e_rate);
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic op(input string tag, input logic rv, input logic ru,
                      input logic [31:0] rq, input logic [31:0] rf,
                      input logic [31:0] mi, input logic [39:0] fi,
                      input logic fe);
        @(negedge clk);
        cur_tag = tag;
        rev_mode = rv; round_up = ru; req_hz = rq; ref_hz = rf;
        mult_in = mi; frac_in = fi; frac_en = fe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0 && rate_out == 0,
            "R11 reset", rate_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_chk = 1'b1;

        // 1 GHz from 19.2 MHz, round up
        op("R3", 0, 1, 32'd1000000000, 32'd19200000, 0, 0, 0);
        chk(mult_out == 52, "R2 mult", 64'(mult_out), 64'd52);
        chk(frac_out == (40'd357913942 << 8), "R3 R5 frac", 64'(frac_out), 64'd357913942 << 8);
        chk(rate_out == 1000000000, "R7 rate", rate_out, 64'd1000000000);
        chk(band_out == 2 && !err, "R8 band", 64'(band_out), 64'd2);

        // same, truncated
        op("R2", 0, 0, 32'd1000000000, 32'd19200000, 0, 0, 0);
        chk(frac_out == (40'd357913941 << 8), "R2 frac", 64'(frac_out), 64'd357913941 << 8);
        chk(rate_out == 999999999, "R6 rate", rate_out, 64'd999999999);

        // exact multiple
        op("R4", 0, 1, 32'd960000000, 32'd19200000, 0, 0, 0);
        chk(frac_out == 0 && mult_out == 50, "R4 frac", 64'(frac_out), 64'd0);
        op("R4", 0, 0, 32'd960000000, 32'd19200000, 0, 0, 0);
        chk(frac_out == 0, "R4 frac trunc", 64'(frac_out), 64'd0);

        // band edges
        op("R8", 0, 1, 32'd500000000, 32'd50000000, 0, 0, 0);
        chk(band_out == 3, "R8 edge 500M", 64'(band_out), 64'd3);
        op("R8", 0, 1, 32'd1500000000, 32'd50000000, 0, 0, 0);
        chk(band_out == 1, "R8 edge 1500M", 64'(band_out), 64'd1);
        op("R8", 0, 1, 32'd2000000000, 32'd50000000, 0, 0, 0);
        chk(band_out == 0 && !err, "R8 edge 2000M", 64'(band_out), 64'd0);
        op("R8", 0, 1, 32'd250000000, 32'd1, 0, 0, 0);
        chk(band_out == 3 && !err, "R8 edge 250M", 64'(band_out), 64'd3);
        op("R8", 0, 1, 32'd249999999, 32'd1, 0, 0, 0);
        chk(err == 1 && mult_out == 0, "R8 below", 64'(err), 64'd1);
        op("R8", 0, 1, 32'd2000000001, 32'd1, 0, 0, 0);
        chk(err == 1 && rate_out == 0, "R8 above", 64'(err), 64'd1);

        // reverse mode
        op("R9", 1, 0, 0, 32'd19200000, 32'd52, {32'd357913942, 8'hAB}, 1);
        chk(rate_out == 1000000000, "R9 rate", rate_out, 64'd1000000000);
        chk(frac_out == (40'd357913942 << 8), "R9 frac", 64'(frac_out), 64'd357913942 << 8);
        op("R9", 1, 0, 0, 32'd19200000, 32'd52, {32'd357913942, 8'hAB}, 0);
        chk(rate_out == 998400000, "R9 frac off", rate_out, 64'd998400000);

        // zero reference
        op("R10", 0, 1, 32'd1000000000, 32'd0, 0, 0, 0);
        chk(err == 1 && busy == 0, "R10 zero ref", 64'(err), 64'd1);
        op("R10", 1, 0, 0, 32'd0, 32'd5, 40'd7, 1);
        chk(err == 1 && mult_out == 0, "R10 zero ref rev", 64'(mult_out), 64'd0);

        // start pulsed mid-division is ignored
        @(negedge clk);
        cur_tag = "R11";
        rev_mode = 0; round_up = 1; req_hz = 32'd1000000000; ref_hz = 32'd19200000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        req_hz = 32'd300000000; ref_hz = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        chk(rate_out == 1000000000, "R11 ignored start", rate_out, 64'd1000000000);
        @(negedge clk);
        chk(done == 0 && rate_out == 1000000000, "R11 hold", rate_out, 64'd1000000000);
        repeat (3) @(negedge clk);

        run_chk = 1'b0;
        finish_run();
    end
endmodule